// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a parameterised number of sources (default 256) and presents one request line to a processor. It also reports, through a status word, the number of the source the processor should serve. Each source has a pending flag, an enable bit and a 5-bit priority. The priority splits into a 3-bit major level and a 2-bit sub level. Every register is reached over a simple synchronous bus. Each register has three write forms: a plain overwrite, an atomic bit-clear and an atomic bit-set, so software never needs a read-modify-write.

Sources come in three kinds:
- **Persistent (level) sources** keep their flag raised for as long as the request line is high. Software cannot clear the flag until the request has dropped.
- **Non-persistent (edge) sources** capture a rising edge of the request. A clear takes effect at once.
- **External pins** (default 8) are first passed through a two-flop synchronizer. They then raise their source's flag on a rising or falling edge, chosen per pin in the control word.

The arbiter picks the pending, enabled source with the largest 5-bit priority. A source whose major level is zero never takes part. Equal priorities go to the lowest source number.

Top module: `vic_top`

## Requirements
- R1: After reset, every flag, enable, priority and control bit reads 0, the status word reads 0 and `irq_o` is low.
- R2: The low address bits [3:2] select the write form. 0 overwrites the register, 1 clears the bits that are 1 in the write data, 2 sets the bits that are 1 in the write data; bits that are 0 in the data stay unchanged under 1 and 2.
- R3: Flag registers start at 0x040 and enable registers at 0x0C0, with a stride of 0x10. Source s uses register s/32 of its group, at bit s%32.
- R4: Priority registers start at 0x140, with a stride of 0x10, four sources to a register. Source s sits in register s/4, lane s%4. Lane bits [4:2] hold the major level and bits [1:0] the sub level. Lane bits [7:5] always read 0.
- R5: A persistent source's flag reads 1 one clock after its request is sampled high. A clear of that flag has no effect while the request is still high. The flag stays 1 after the request drops, until software clears it.
- R6: A non-persistent source's flag is set by a rising edge of its request. A clear empties it in the next cycle. A request held high does not set the flag again.
- R7: Source EXT_BASE+i follows external pin i. Its flag is set three clocks after the pin changes in the direction chosen by control bit i (1 = rising, 0 = falling). A change in the other direction sets nothing, and the src_req bit of that source is ignored.
- R8: The status word bits [7:0] name the pending, enabled source with the largest 5-bit priority; on a tie, the lowest source number wins.
- R9: A source with major level 0, or with its enable bit at 0, never wins and never raises `irq_o`.
- R10: `irq_o` is high exactly when some source is pending, enabled and of nonzero major level. When it is low, the status word reads 0.
- R11: Writes to the status word, and writes with address bits [3:2] = 3, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| src_req | input | N_SRC | Request lines of the internal sources, synchronous to `clk` |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The checker assumes that `src_req` is synchronous to `clk`. It also assumes that `ext_pin` is low when reset is released, so that synchronizer start-up is not taken for an edge. The bench drives every input only on the falling clock edge, holds the pins low through reset, and holds each pin level for at least four clocks so that the synchronizer sees every change. During the arbitration sweeps the bench keeps all internal requests low, so persistent flags can be cleared and the bench's flag model stays exact.

// File: rtl/vic_pkg.sv
`timescale 1ns/100ps
package vic_pkg;
    localparam int VEC_W   = 8;
    localparam int PRI_W   = 5;
    localparam int MAJ_LSB = 2;
    localparam int WORD_W  = 32;
    localparam int LANE_W  = 8;

    localparam logic [11:0] CTRL_BASE = 12'h000;
    localparam logic [11:0] STAT_BASE = 12'h020;
    localparam logic [11:0] FLAG_BASE = 12'h040;
    localparam logic [11:0] EN_BASE   = 12'h0C0;
    localparam logic [11:0] PRI_BASE  = 12'h140;

    // write form, chosen by address bits [3:2]
    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_CLR   = 2'd1,
        ACC_SET   = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic [PRI_W-1:0]  pri;
        logic [VEC_W-1:0]  vec;
    } cand_t;

    function automatic logic [WORD_W-1:0] apply_acc(acc_e kind,
                                                    logic [WORD_W-1:0] cur,
                                                    logic [WORD_W-1:0] wd);
        logic [WORD_W-1:0] r;
        unique case (kind)
            ACC_WRITE: r = wd;
            ACC_CLR:   r = cur & ~wd;
            ACC_SET:   r = cur | wd;
            default:   r = cur;
        endcase
        return r;
    endfunction

    // lo covers the lower source numbers; hi wins only on strictly larger priority
    function automatic cand_t pick_cand(cand_t lo, cand_t hi);
        cand_t r;
        if (hi.valid && (!lo.valid || (hi.pri > lo.pri)))
            r = hi;
        else
            r = lo;
        return r;
    endfunction
endpackage

// File: rtl/vic_ext_edge.sv
`timescale 1ns/100ps
module vic_ext_edge #(
    parameter int N_EXT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] pin,
    input  logic [N_EXT-1:0] rise_sel,
    output logic [N_EXT-1:0] pulse
);
    logic [N_EXT-1:0] meta_q;
    logic [N_EXT-1:0] sync_q;
    logic [N_EXT-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        assign pulse[i] = rise_sel[i] ? (sync_q[i] & ~hist_q[i])
                                      : (~sync_q[i] & hist_q[i]);
    end
endmodule

// File: rtl/vic_flag_bank.sv
`timescale 1ns/100ps
module vic_flag_bank import vic_pkg::*; #(
    parameter int              N_SRC    = 256,
    parameter int              N_EXT    = 8,
    parameter int              EXT_BASE = 16,
    parameter logic [N_SRC-1:0] LVL_EFF = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic [N_EXT-1:0]  ext_pulse,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  acc_e              acc,
    input  logic [WORD_W-1:0] wdata,
    output logic [N_SRC-1:0]  flag_q
);
    localparam int N_WORD = N_SRC / WORD_W;

    logic [N_SRC-1:0] req_prev_q;
    logic [N_SRC-1:0] bus_val;
    logic [N_SRC-1:0] flag_d;

    for (genvar w = 0; w < N_WORD; w++) begin : g_word
        assign bus_val[w*WORD_W +: WORD_W] =
            (wr_en && (wr_idx == 8'(w))) ? apply_acc(acc, flag_q[w*WORD_W +: WORD_W], wdata)
                                         : flag_q[w*WORD_W +: WORD_W];
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        localparam bit IS_EXT = (s >= EXT_BASE) && (s < EXT_BASE + N_EXT);
        logic evt;
        if (IS_EXT) begin : g_ext
            assign evt = ext_pulse[s - EXT_BASE];
        end else if (LVL_EFF[s]) begin : g_lvl
            // request ORed in after the bus: a clear cannot win while asserted
            assign evt = src_req[s];
        end else begin : g_edge
            assign evt = src_req[s] & ~req_prev_q[s];
        end
        assign flag_d[s] = bus_val[s] | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q     <= '0;
            req_prev_q <= '0;
        end else begin
            flag_q     <= flag_d;
            req_prev_q <= src_req;
        end
    end
endmodule

// File: rtl/vic_mask_regs.sv
`timescale 1ns/100ps
module vic_mask_regs import vic_pkg::*; #(
    parameter int N_SRC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [7:0]        en_idx,
    input  logic              pri_wr,
    input  logic [7:0]        pri_idx,
    input  acc_e              acc,
    input  logic [WORD_W-1:0] wdata,
    output logic [N_SRC-1:0]  en_q,
    output logic [PRI_W-1:0]  pri_q [N_SRC]
);
    localparam int N_WORD  = N_SRC / WORD_W;
    localparam int LANES   = WORD_W / LANE_W;
    localparam int N_PWORD = N_SRC / LANES;

    logic [N_SRC-1:0] en_d;
    logic [PRI_W-1:0] pri_d [N_SRC];

    for (genvar w = 0; w < N_WORD; w++) begin : g_en
        assign en_d[w*WORD_W +: WORD_W] =
            (en_wr && (en_idx == 8'(w))) ? apply_acc(acc, en_q[w*WORD_W +: WORD_W], wdata)
                                         : en_q[w*WORD_W +: WORD_W];
    end

    for (genvar p = 0; p < N_PWORD; p++) begin : g_pw
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] nxt;
        for (genvar l = 0; l < LANES; l++) begin : g_lane_rd
            assign cur[l*LANE_W +: LANE_W] = {{(LANE_W-PRI_W){1'b0}}, pri_q[p*LANES+l]};
        end
        assign nxt = (pri_wr && (pri_idx == 8'(p))) ? apply_acc(acc, cur, wdata) : cur;
        for (genvar l = 0; l < LANES; l++) begin : g_lane_wr
            assign pri_d[p*LANES+l] = nxt[l*LANE_W +: PRI_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pri_q <= '{default: '0};
        end else begin
            en_q  <= en_d;
            pri_q <= pri_d;
        end
    end
endmodule

// File: rtl/vic_arb_tree.sv
`timescale 1ns/100ps
module vic_arb_tree import vic_pkg::*; #(
    parameter int N_SRC = 256
) (
    input  logic [N_SRC-1:0] live,
    input  logic [PRI_W-1:0] pri [N_SRC],
    output cand_t            win
);
    // heap layout: node i has children 2i (lower numbers) and 2i+1
    cand_t node [1:2*N_SRC-1];

    for (genvar s = 0; s < N_SRC; s++) begin : g_leaf
        assign node[N_SRC+s] = '{valid: live[s], pri: pri[s], vec: VEC_W'(s)};
    end

    for (genvar i = 1; i < N_SRC; i++) begin : g_node
        assign node[i] = pick_cand(node[2*i], node[2*i+1]);
    end

    assign win = node[1];
endmodule

// File: rtl/vic_top.sv
`timescale 1ns/100ps
module vic_top import vic_pkg::*; #(
    parameter int               N_SRC      = 256,
    parameter int               N_EXT      = 8,
    parameter int               EXT_BASE   = 16,
    parameter logic [N_SRC-1:0] LEVEL_MASK = {(N_SRC/2){2'b01}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_SRC-1:0]  src_req,
    input  logic [N_EXT-1:0]  ext_pin,
    output logic              irq_o
);
    localparam int N_WORD    = N_SRC / WORD_W;
    localparam int LANES     = WORD_W / LANE_W;
    localparam int N_PWORD   = N_SRC / LANES;
    localparam int FLAG_SPAN = N_WORD * 16;
    localparam int PRI_SPAN  = N_PWORD * 16;

    function automatic logic [N_SRC-1:0] ext_mask_f();
        logic [N_SRC-1:0] m;
        m = '0;
        for (int i = 0; i < N_EXT; i++) m[EXT_BASE+i] = 1'b1;
        return m;
    endfunction

    localparam logic [N_SRC-1:0] LVL_EFF = LEVEL_MASK & ~ext_mask_f();

    // ---------------- address decode ----------------
    logic [11:0] off_flag, off_en, off_pri;
    logic        hit_ctrl, hit_stat, hit_flag, hit_en, hit_pri;
    acc_e        acc;

    assign off_flag = bus_addr - FLAG_BASE;
    assign off_en   = bus_addr - EN_BASE;
    assign off_pri  = bus_addr - PRI_BASE;
    assign hit_ctrl = bus_addr[11:4] == CTRL_BASE[11:4];
    assign hit_stat = bus_addr[11:4] == STAT_BASE[11:4];
    assign hit_flag = (bus_addr >= FLAG_BASE) && (int'(off_flag) < FLAG_SPAN);
    assign hit_en   = (bus_addr >= EN_BASE)   && (int'(off_en)   < FLAG_SPAN);
    assign hit_pri  = (bus_addr >= PRI_BASE)  && (int'(off_pri)  < PRI_SPAN);
    assign acc      = acc_e'(bus_addr[3:2]);

    // ---------------- control word: edge direction per pin ----------------
    logic [N_EXT-1:0]  ctrl_q;
    logic [WORD_W-1:0] ctrl_nxt;

    assign ctrl_nxt = apply_acc(acc, WORD_W'(ctrl_q), bus_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_we && hit_ctrl)
            ctrl_q <= ctrl_nxt[N_EXT-1:0];
    end

    // ---------------- sub-blocks ----------------
    logic [N_EXT-1:0] ext_pulse;
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] en_q;
    logic [PRI_W-1:0] pri_q [N_SRC];
    logic [N_SRC-1:0] live;
    cand_t            win;
    logic [VEC_W-1:0] win_vec;

    vic_ext_edge #(.N_EXT(N_EXT)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .rise_sel (ctrl_q),
        .pulse    (ext_pulse)
    );

    vic_flag_bank #(
        .N_SRC    (N_SRC),
        .N_EXT    (N_EXT),
        .EXT_BASE (EXT_BASE),
        .LVL_EFF  (LVL_EFF)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .ext_pulse (ext_pulse),
        .wr_en     (bus_we && hit_flag),
        .wr_idx    (off_flag[11:4]),
        .acc       (acc),
        .wdata     (bus_wdata),
        .flag_q    (flag_q)
    );

    vic_mask_regs #(.N_SRC(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (bus_we && hit_en),
        .en_idx  (off_en[11:4]),
        .pri_wr  (bus_we && hit_pri),
        .pri_idx (off_pri[11:4]),
        .acc     (acc),
        .wdata   (bus_wdata),
        .en_q    (en_q),
        .pri_q   (pri_q)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_live
        assign live[s] = flag_q[s] & en_q[s] & (pri_q[s][PRI_W-1:MAJ_LSB] != '0);
    end

    vic_arb_tree #(.N_SRC(N_SRC)) u_arb (
        .live (live),
        .pri  (pri_q),
        .win  (win)
    );

    assign win_vec = win.vec;
    assign irq_o   = win.valid;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata = WORD_W'(ctrl_q);
        end else if (hit_stat) begin
            bus_rdata = {{(WORD_W-VEC_W){1'b0}}, win_vec};
        end else if (hit_flag) begin
            for (int w = 0; w < N_WORD; w++)
                if (off_flag[11:4] == 8'(w)) bus_rdata = flag_q[w*WORD_W +: WORD_W];
        end else if (hit_en) begin
            for (int w = 0; w < N_WORD; w++)
                if (off_en[11:4] == 8'(w)) bus_rdata = en_q[w*WORD_W +: WORD_W];
        end else if (hit_pri) begin
            for (int p = 0; p < N_PWORD; p++)
                if (off_pri[11:4] == 8'(p))
                    for (int l = 0; l < LANES; l++)
                        bus_rdata[l*LANE_W +: LANE_W] = {{(LANE_W-PRI_W){1'b0}}, pri_q[p*LANES+l]};
        end
    end
endmodule

// File: rtl/vic_chk.sv
`timescale 1ns/100ps
module vic_chk import vic_pkg::*; #(
    parameter int               N_SRC    = 256,
    parameter logic [N_SRC-1:0] LVL_ONLY = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_req,
    input logic [N_SRC-1:0] flag_q,
    input logic [N_SRC-1:0] en_q,
    input logic [PRI_W-1:0] pri_q [N_SRC],
    input logic [VEC_W-1:0] win_vec,
    input logic             irq_o
);
    logic [N_SRC-1:0] elig;

    for (genvar s = 0; s < N_SRC; s++) begin : g_elig
        assign elig[s] = flag_q[s] && en_q[s] && (pri_q[s][PRI_W-1:MAJ_LSB] != 3'd0);
    end

    assert_irq_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|elig));

    assert_idle_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (win_vec == '0));

    assert_win_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> elig[win_vec]);

    for (genvar s = 0; s < N_SRC; s++) begin : g_order
        assert_win_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o && elig[s]) |->
                ((pri_q[win_vec] > pri_q[s]) ||
                 ((pri_q[win_vec] == pri_q[s]) && (win_vec <= VEC_W'(s)))));
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_lvl
        if (LVL_ONLY[s]) begin : g_on
            assert_level_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
                src_req[s] |=> flag_q[s]);
        end
    end
endmodule

bind vic_top vic_chk #(.N_SRC(N_SRC), .LVL_ONLY(LVL_EFF)) u_vic_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_req (src_req),
    .flag_q  (flag_q),
    .en_q    (en_q),
    .pri_q   (pri_q),
    .win_vec (win_vec),
    .irq_o   (irq_o)
);

// File: tb/tb_vic_top.sv
`timescale 1ns/100ps
module tb_vic_top;
    localparam int NS = 64;
    localparam int NE = 4;
    localparam int EB = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] src_req = '0;
    logic [NE-1:0] ext_pin = '0;
    logic          irq_o;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    bit          exp_flag [NS];
    bit          exp_en   [NS];
    logic [4:0]  exp_pri  [NS];

    always #2.5 clk = ~clk;

    vic_top #(.N_SRC(NS), .N_EXT(NE), .EXT_BASE(EB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .ext_pin(ext_pin), .irq_o(irq_o)
    );

    function automatic logic [11:0] fa(int s, int al);
        return 12'h040 + 12'((s/32)*16 + al*4);
    endfunction
    function automatic logic [11:0] ea(int s, int al);
        return 12'h0C0 + 12'((s/32)*16 + al*4);
    endfunction
    function automatic logic [11:0] pa(int s, int al);
        return 12'h140 + 12'((s/4)*16 + al*4);
    endfunction
    function automatic bit is_ext(int s);
        return (s >= EB) && (s < EB + NE);
    endfunction

    function automatic logic [4:0] pri_of(int k, int s);
        case (k)
            0:       return 5'((s*13 + 5) % 32);
            1:       return 5'((s*7 + 11) % 32);
            2:       return (s % 5 == 2) ? 5'd31 : 5'(s % 32);
            default: return 5'd8;
        endcase
    endfunction

    function automatic int model_win();
        int b = -1;
        for (int s = 0; s < NS; s++)
            if (exp_flag[s] && exp_en[s] && (exp_pri[s][4:2] != 3'd0))
                if (b < 0 || exp_pri[s] > exp_pri[b]) b = s;
        return b;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_arb(string tag);
        int w;
        logic [31:0] d;
        w = model_win();
        rd(12'h020, d);
        chk({tag, " status"}, d, (w < 0) ? 32'd0 : 32'(w));
        chk({tag, " irq"}, {31'd0, irq_o}, (w >= 0) ? 32'd1 : 32'd0);
    endtask

    task automatic load_pri(int k);
        logic [31:0] d;
        for (int p = 0; p < NS/4; p++) begin
            d = '0;
            for (int l = 0; l < 4; l++) begin
                d[l*8 +: 8] = {3'b101, pri_of(k, p*4+l)};
                exp_pri[p*4+l] = pri_of(k, p*4+l);
            end
            wr(pa(p*4, 0), d);
        end
    endtask

    task automatic set_all_flags();
        wr(fa(0, 0), 32'hFFFF_FFFF);
        wr(fa(32, 0), 32'hFFFF_FFFF);
        for (int s = 0; s < NS; s++) exp_flag[s] = 1;
    endtask

    task automatic drain(string tag);
        int w;
        for (int n = 0; n <= NS; n++) begin
            check_arb(tag);
            w = model_win();
            if (w < 0) break;
            wr(fa(w, 1), 32'd1 << (w % 32));
            exp_flag[w] = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        for (int s = 0; s < NS; s++) begin
            exp_flag[s] = 0; exp_en[s] = 0; exp_pri[s] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < NS/32; w++) begin
            rd(fa(w*32, 0), d); chk("R1 flag reset", d, 0);
            rd(ea(w*32, 0), d); chk("R1 enable reset", d, 0);
        end
        for (int p = 0; p < NS/4; p++) begin
            rd(pa(p*4, 0), d); chk("R1 priority reset", d, 0);
        end
        rd(12'h000, d); chk("R1 control reset", d, 0);
        rd(12'h020, d); chk("R1 status reset", d, 0);
        chk("R1 irq reset", {31'd0, irq_o}, 0);

        // R2 / R11: write forms on enable registers
        for (int w = 0; w < NS/32; w++) begin
            wr(ea(w*32, 0), 32'hA5A5_0F0F);
            rd(ea(w*32, 0), d); chk("R2 plain write", d, 32'hA5A5_0F0F);
            wr(ea(w*32, 2), 32'h0000_F000);
            rd(ea(w*32, 0), d); chk("R2 set form", d, 32'hA5A5_FF0F);
            wr(ea(w*32, 1), 32'h8000_0F01);
            rd(ea(w*32, 0), d); chk("R2 clear form", d, 32'h25A5_F00E);
            wr(ea(w*32, 3), 32'hFFFF_FFFF);
            rd(ea(w*32, 0), d); chk("R11 reserved form ignored", d, 32'h25A5_F00E);
            wr(ea(w*32, 0), 32'h0);
        end
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, d); chk("R11 status write ignored", d, 0);
        chk("R11 irq after status write", {31'd0, irq_o}, 0);

        // R4: priority lanes, upper lane bits dropped
        load_pri(0);
        for (int p = 0; p < NS/4; p++) begin
            rd(pa(p*4, 0), d);
            chk("R4 priority lanes", d, {3'b0, exp_pri[p*4+3], 3'b0, exp_pri[p*4+2],
                                         3'b0, exp_pri[p*4+1], 3'b0, exp_pri[p*4]});
        end
        wr(pa(8, 1), 32'hFFFF_FFFF);
        rd(pa(8, 0), d); chk("R4 R2 priority clear form", d, 0);
        wr(pa(8, 2), 32'h0000_1C00);
        rd(pa(8, 0), d); chk("R4 R2 priority set form lane1 major", d, 32'h0000_1C00);
        exp_pri[8] = 0; exp_pri[9] = 5'h1C; exp_pri[10] = 0; exp_pri[11] = 0;

        // R3 / R5 / R6: per-source flag sweep
        for (int s = 0; s < NS; s++) begin
            if (is_ext(s)) continue;
            @(negedge clk);
            src_req[s] = 1'b1;
            @(negedge clk);
            rd(fa(s, 0), d); chk("R3 flag bit position", d, 32'd1 << (s % 32));
            rd(fa(s + 32*(1 - 2*(s/32)), 0), d); chk("R3 other flag register", d, 0);
            if (s % 2 == 0) begin
                wr(fa(s, 1), 32'd1 << (s % 32));
                rd(fa(s, 0), d); chk("R5 clear refused while asserted", d, 32'd1 << (s % 32));
                src_req[s] = 1'b0;
                repeat (2) @(negedge clk);
                rd(fa(s, 0), d); chk("R5 flag kept after release", d, 32'd1 << (s % 32));
                wr(fa(s, 1), 32'd1 << (s % 32));
                rd(fa(s, 0), d); chk("R5 clear after release", d, 0);
            end else begin
                wr(fa(s, 1), 32'd1 << (s % 32));
                rd(fa(s, 0), d); chk("R6 clear while held", d, 0);
                repeat (3) @(negedge clk);
                rd(fa(s, 0), d); chk("R6 no retrigger while held", d, 0);
                src_req[s] = 1'b0;
                @(negedge clk);
            end
        end

        // R7: external pins
        for (int i = 0; i < NE; i++) begin
            wr(12'h008, 32'd1 << i);
            @(negedge clk); ext_pin[i] = 1'b1;
            @(negedge clk); @(negedge clk);
            rd(fa(EB+i, 0), d); chk("R7 rising not yet through synchronizer", d, 0);
            @(negedge clk);
            rd(fa(EB+i, 0), d); chk("R7 rising edge captured", d, 32'd1 << ((EB+i) % 32));
            wr(fa(EB+i, 1), 32'd1 << ((EB+i) % 32));
            ext_pin[i] = 1'b0;
            repeat (4) @(negedge clk);
            rd(fa(EB+i, 0), d); chk("R7 falling ignored on rising pin", d, 0);
            wr(12'h004, 32'd1 << i);
            rd(12'h000, d); chk("R7 control bit cleared", d, 0);
            ext_pin[i] = 1'b1;
            repeat (4) @(negedge clk);
            rd(fa(EB+i, 0), d); chk("R7 rising ignored on falling pin", d, 0);
            ext_pin[i] = 1'b0;
            @(negedge clk); @(negedge clk); @(negedge clk);
            rd(fa(EB+i, 0), d); chk("R7 falling edge captured", d, 32'd1 << ((EB+i) % 32));
            wr(fa(EB+i, 1), 32'd1 << ((EB+i) % 32));
            @(negedge clk); src_req[EB+i] = 1'b1;
            @(negedge clk); src_req[EB+i] = 1'b0;
            @(negedge clk);
            rd(fa(EB+i, 0), d); chk("R7 src_req of pin source ignored", d, 0);
        end

        // R9 / R10: flags pending but nothing enabled
        load_pri(0);
        set_all_flags();
        check_arb("R9 all disabled");

        // R8 / R9: single-enable sweep
        for (int s = 0; s < NS; s++) begin
            wr(ea(0, 0), (s < 32) ? (32'd1 << s) : 32'd0);
            wr(ea(32, 0), (s >= 32) ? (32'd1 << (s - 32)) : 32'd0);
            for (int t = 0; t < NS; t++) exp_en[t] = (t == s);
            check_arb("R9 single source");
        end

        // R8 / R10: drains with several priority patterns
        wr(ea(0, 0), 32'hFFFF_FFFF);
        wr(ea(32, 0), 32'hFFFF_FFFF);
        for (int t = 0; t < NS; t++) exp_en[t] = 1;
        for (int k = 0; k < 4; k++) begin
            load_pri(k);
            set_all_flags();
            drain("R8 drain");
            wr(fa(0, 0), 32'h0);
            wr(fa(32, 0), 32'h0);
            for (int t = 0; t < NS; t++) exp_flag[t] = 0;
            check_arb("R10 all cleared");
        end

        finish_run();
    end
endmodule